// File: doc/BRIEF.md
# Load Queue with Store-Order Violation Detection

This block keeps the in-flight loads of an out-of-order core in a circular queue, in program order. Each entry holds the load's sequence number, the store-queue position the load was allocated behind, and, once the load has executed, its effective address. Commit retires entries from the head. A squash removes entries from the tail. When a store executes, the block checks the loads allocated after that store for an address-block match, which is a memory-ordering violation.

Allocation is a valid/ready stream. The producer holds `alloc_valid` and its payload until it sees `alloc_ready`. A transfer happens on a rising edge where both are high. `alloc_ready` drops when the queue is full or a squash is present. The violator report is a valid/ready stream toward the pipeline. Once raised, it holds its payload until it is taken with `vio_ready`, and no new report can replace it. Commit, squash, store check, address update and the blocked-load marker are plain single-cycle control pins.

Top module: `lq_load_queue`

## Requirements
- R1: The queue has DEPTH usable entries in DEPTH+1 slots. `alloc_ready` is low while DEPTH entries are held. An accepted load is written at slot `ld_tail`, which `alloc_idx` reports. The tail then advances, wrapping from slot DEPTH to slot 0.
- R2: Each entry records the store-queue tail given at allocation. `head_sq_idx` shows the value for the head entry: the tail zero-extended, or -1 (all ones) when `alloc_sq_empty` was high.
- R3: A newly allocated entry counts as unexecuted and never matches a store. It becomes executed when `addr_valid` writes `addr_value` to slot `addr_idx`.
- R4: When `st_valid` is high, the block scans slots from `st_ld_idx` up to, but not including, `ld_tail`. It looks for an executed load whose address shifted right by BLK_SHIFT equals the store address shifted right by BLK_SHIFT. The first match in program order is reported on `vio_valid`/`vio_idx`/`vio_seq` from the next cycle.
- R5: A raised violator keeps its payload until a cycle with `vio_ready` high, and drops after that cycle. A store check in any cycle where `vio_valid` is high is ignored.
- R6: With `commit_valid`, the block frees head entries in order while their sequence number is at most `commit_seq` (unsigned compare). It stops at the first younger entry.
- R7: With `squash_valid`, the block removes entries backward from the newest while their sequence number is greater than `squash_seq`. The tail moves back one slot per removed entry and wraps from slot 0 to slot DEPTH.
- R8: In a cycle with `squash_valid`, `alloc_ready` is low and `commit_valid` has no effect.
- R9: `blk_set` marks a blocked load with sequence number `blk_seq` and raises `blk_pending`. A squash whose `squash_seq` is lower than that number clears `blk_pending`. A squash whose number is equal or higher leaves it set. `blk_set` wins over a clearing squash in the same cycle.
- R10: After reset the queue is empty, `ld_tail` is 0, and `vio_valid` and `blk_pending` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Load allocation offered |
| alloc_ready | output | 1 | Queue can accept a load |
| alloc_seq | input | SEQ_W | Sequence number of the load |
| alloc_sq_tail | input | SQ_IDX_W | Current store-queue tail |
| alloc_sq_empty | input | 1 | Store queue holds no stores |
| alloc_idx | output | IDX_W | Slot the offered load takes |
| addr_valid | input | 1 | Load executed, address available |
| addr_idx | input | IDX_W | Slot of the executed load |
| addr_value | input | ADDR_W | Effective address of the load |
| st_valid | input | 1 | A store executes this cycle |
| st_ld_idx | input | IDX_W | Load tail recorded by the store |
| st_addr | input | ADDR_W | Effective address of the store |
| commit_valid | input | 1 | Commit report |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Last surviving sequence number |
| blk_set | input | 1 | Mark a blocked load |
| blk_seq | input | SEQ_W | Sequence number of the blocked load |
| blk_pending | output | 1 | Blocked load outstanding |
| vio_valid | output | 1 | Violator held |
| vio_ready | input | 1 | Pipeline takes the violator |
| vio_idx | output | IDX_W | Slot of the violating load |
| vio_seq | output | SEQ_W | Sequence number of the violating load |
| ld_tail | output | IDX_W | Next free slot |
| ld_count | output | CNT_W | Entries held |
| head_valid | output | 1 | Head entry present |
| head_seq | output | SEQ_W | Sequence number at the head |
| head_sq_idx | output | SQ_IDX_W+1 | Signed store index of the head entry |

## Verification
On every cycle the assertions check the occupancy rules: one step of growth per accepted load, no growth from commit or squash, and the DEPTH ceiling. They also check the violator handshake, which must keep its payload while held, drop after being read, and never rise without a store check. They check the squash blocking on allocation and the clearing of the blocked marker as well. Only the bench scenarios can show that the right entries go away: which slot is reported as the first offender, where an in-order commit run stops, how a squash walks back across slot 0, and the address-block boundary at BLK_SHIFT.

// File: rtl/lq_pkg.sv
package lq_pkg;

  // Circular index helpers for a ring of 'slots' entries (not a power of two).
  function automatic int ring_fwd(int idx, int off, int slots);
    return (idx + off) % slots;
  endfunction

  function automatic int ring_back(int idx, int off, int slots);
    return (idx + slots - off) % slots;
  endfunction

  function automatic int ring_gap(int from_idx, int to_idx, int slots);
    return (to_idx - from_idx + slots) % slots;
  endfunction

endpackage

// File: rtl/lq_retire_scan.sv
// Counts the run of head entries old enough to retire.
module lq_retire_scan #(
  parameter int SLOTS = 9,
  parameter int IDX_W = 4,
  parameter int CNT_W = 4,
  parameter int SEQ_W = 16
) (
  input  logic [IDX_W-1:0] head,
  input  logic [CNT_W-1:0] count,
  input  logic [SEQ_W-1:0] seq_tbl [SLOTS],
  input  logic [SEQ_W-1:0] limit,
  output logic [CNT_W-1:0] n_free
);
  always_comb begin
    logic run;
    int   n;
    run = 1'b1;
    n   = 0;
    for (int k = 0; k < SLOTS; k++) begin
      logic [IDX_W-1:0] i;
      i = IDX_W'(lq_pkg::ring_fwd(int'(head), k, SLOTS));
      if (run && k < int'(count) && seq_tbl[i] <= limit) n++;
      else run = 1'b0;
    end
    n_free = CNT_W'(n);
  end
endmodule

// File: rtl/lq_squash_scan.sv
// Counts the run of tail entries younger than the squash point.
module lq_squash_scan #(
  parameter int SLOTS = 9,
  parameter int IDX_W = 4,
  parameter int CNT_W = 4,
  parameter int SEQ_W = 16
) (
  input  logic [IDX_W-1:0] tail,
  input  logic [CNT_W-1:0] count,
  input  logic [SEQ_W-1:0] seq_tbl [SLOTS],
  input  logic [SEQ_W-1:0] limit,
  output logic [CNT_W-1:0] n_kill
);
  always_comb begin
    logic run;
    int   n;
    run = 1'b1;
    n   = 0;
    for (int k = 0; k < SLOTS; k++) begin
      logic [IDX_W-1:0] i;
      i = IDX_W'(lq_pkg::ring_back(int'(tail), k + 1, SLOTS));
      if (run && k < int'(count) && seq_tbl[i] > limit) n++;
      else run = 1'b0;
    end
    n_kill = CNT_W'(n);
  end
endmodule

// File: rtl/lq_order_check.sv
// Finds the oldest executed load after a store that shares its address block.
module lq_order_check #(
  parameter int SLOTS     = 9,
  parameter int IDX_W     = 4,
  parameter int ADDR_W    = 32,
  parameter int BLK_SHIFT = 8
) (
  input  logic [IDX_W-1:0]  start,
  input  logic [IDX_W-1:0]  tail,
  input  logic [ADDR_W-1:0] addr_tbl [SLOTS],
  input  logic [SLOTS-1:0]  exec_tbl,
  input  logic [ADDR_W-1:0] st_addr,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);
  localparam int BLK_W = ADDR_W - BLK_SHIFT;

  logic [BLK_W-1:0] st_blk;
  assign st_blk = st_addr[ADDR_W-1:BLK_SHIFT];

  always_comb begin
    int gap;
    hit     = 1'b0;
    hit_idx = '0;
    gap     = lq_pkg::ring_gap(int'(start), int'(tail), SLOTS);
    for (int k = 0; k < SLOTS; k++) begin
      logic [IDX_W-1:0] i;
      i = IDX_W'(lq_pkg::ring_fwd(int'(start), k, SLOTS));
      if (!hit && k < gap && exec_tbl[i] &&
          addr_tbl[i][ADDR_W-1:BLK_SHIFT] == st_blk) begin
        hit     = 1'b1;
        hit_idx = i;
      end
    end
  end
endmodule

// File: rtl/lq_load_queue.sv
module lq_load_queue #(
  parameter int DEPTH     = 8,
  parameter int SEQ_W     = 16,
  parameter int ADDR_W    = 32,
  parameter int SQ_IDX_W  = 4,
  parameter int BLK_SHIFT = 8,
  localparam int SLOTS    = DEPTH + 1,
  localparam int IDX_W    = $clog2(SLOTS),
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc_valid,
  output logic                  alloc_ready,
  input  logic [SEQ_W-1:0]      alloc_seq,
  input  logic [SQ_IDX_W-1:0]   alloc_sq_tail,
  input  logic                  alloc_sq_empty,
  output logic [IDX_W-1:0]      alloc_idx,
  input  logic                  addr_valid,
  input  logic [IDX_W-1:0]      addr_idx,
  input  logic [ADDR_W-1:0]     addr_value,
  input  logic                  st_valid,
  input  logic [IDX_W-1:0]      st_ld_idx,
  input  logic [ADDR_W-1:0]     st_addr,
  input  logic                  commit_valid,
  input  logic [SEQ_W-1:0]      commit_seq,
  input  logic                  squash_valid,
  input  logic [SEQ_W-1:0]      squash_seq,
  input  logic                  blk_set,
  input  logic [SEQ_W-1:0]      blk_seq,
  output logic                  blk_pending,
  output logic                  vio_valid,
  input  logic                  vio_ready,
  output logic [IDX_W-1:0]      vio_idx,
  output logic [SEQ_W-1:0]      vio_seq,
  output logic [IDX_W-1:0]      ld_tail,
  output logic [CNT_W-1:0]      ld_count,
  output logic                  head_valid,
  output logic [SEQ_W-1:0]      head_seq,
  output logic signed [SQ_IDX_W:0] head_sq_idx
);

  // Entry storage
  logic [SEQ_W-1:0]         seq_q  [SLOTS];
  logic [ADDR_W-1:0]        addr_q [SLOTS];
  logic signed [SQ_IDX_W:0] sqi_q  [SLOTS];
  logic [SLOTS-1:0]         exec_q;

  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;

  logic             vio_q;
  logic [IDX_W-1:0] vio_idx_q;
  logic [SEQ_W-1:0] vio_seq_q;

  logic             blk_q;
  logic [SEQ_W-1:0] blk_seq_q;

  // Control decode
  logic do_squash, do_commit, alloc_fire;
  assign do_squash  = squash_valid;
  assign do_commit  = commit_valid && !squash_valid;
  assign alloc_ready = !squash_valid && (count_q < CNT_W'(DEPTH));
  assign alloc_fire = alloc_valid && alloc_ready;

  logic [CNT_W-1:0] n_free, n_kill;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;

  lq_retire_scan #(.SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W), .SEQ_W(SEQ_W)) u_retire (
    .head(head_q), .count(count_q), .seq_tbl(seq_q), .limit(commit_seq), .n_free(n_free)
  );

  lq_squash_scan #(.SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W), .SEQ_W(SEQ_W)) u_squash (
    .tail(tail_q), .count(count_q), .seq_tbl(seq_q), .limit(squash_seq), .n_kill(n_kill)
  );

  lq_order_check #(.SLOTS(SLOTS), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT)) u_order (
    .start(st_ld_idx), .tail(tail_q), .addr_tbl(addr_q), .exec_tbl(exec_q),
    .st_addr(st_addr), .hit(hit), .hit_idx(hit_idx)
  );

  // Pointer and occupancy next state
  logic [CNT_W-1:0] freed, killed;
  logic [IDX_W-1:0] head_d, tail_d;
  logic [CNT_W-1:0] count_d;

  always_comb begin
    freed  = do_commit ? n_free : '0;
    killed = do_squash ? n_kill : '0;
    head_d = IDX_W'(lq_pkg::ring_fwd(int'(head_q), int'(freed), SLOTS));
    if (do_squash)
      tail_d = IDX_W'(lq_pkg::ring_back(int'(tail_q), int'(killed), SLOTS));
    else if (alloc_fire)
      tail_d = IDX_W'(lq_pkg::ring_fwd(int'(tail_q), 1, SLOTS));
    else
      tail_d = tail_q;
    count_d = count_q - freed - killed + CNT_W'(alloc_fire);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
    end
  end

  // Entry writes: address update first, allocation of the tail slot last
  always_ff @(posedge clk) begin
    if (addr_valid)
      addr_q[addr_idx] <= addr_value;
    if (alloc_fire) begin
      seq_q[tail_q] <= alloc_seq;
      sqi_q[tail_q] <= alloc_sq_empty ? '1 : {1'b0, alloc_sq_tail};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exec_q <= '0;
    end else begin
      if (addr_valid) exec_q[addr_idx] <= 1'b1;
      if (alloc_fire) exec_q[tail_q]   <= 1'b0;
    end
  end

  // Sticky violator: scan result captured only while nothing is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vio_q     <= 1'b0;
      vio_idx_q <= '0;
      vio_seq_q <= '0;
    end else if (vio_q) begin
      if (vio_ready) vio_q <= 1'b0;
    end else if (st_valid && hit) begin
      vio_q     <= 1'b1;
      vio_idx_q <= hit_idx;
      vio_seq_q <= seq_q[hit_idx];
    end
  end

  // Blocked-load marker
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q     <= 1'b0;
      blk_seq_q <= '0;
    end else if (blk_set) begin
      blk_q     <= 1'b1;
      blk_seq_q <= blk_seq;
    end else if (squash_valid && blk_q && squash_seq < blk_seq_q) begin
      blk_q <= 1'b0;
    end
  end

  assign alloc_idx   = tail_q;
  assign ld_tail     = tail_q;
  assign ld_count    = count_q;
  assign head_valid  = (count_q != '0);
  assign head_seq    = seq_q[head_q];
  assign head_sq_idx = sqi_q[head_q];
  assign vio_valid   = vio_q;
  assign vio_idx     = vio_idx_q;
  assign vio_seq     = vio_seq_q;
  assign blk_pending = blk_q;

endmodule

// File: rtl/lq_load_queue_chk.sv
module lq_load_queue_chk #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  parameter int IDX_W = 4,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic             commit_valid,
  input logic             squash_valid,
  input logic [SEQ_W-1:0] squash_seq,
  input logic             blk_set,
  input logic [SEQ_W-1:0] blk_seq,
  input logic             blk_pending,
  input logic             st_valid,
  input logic             vio_valid,
  input logic             vio_ready,
  input logic [IDX_W-1:0] vio_idx,
  input logic [SEQ_W-1:0] vio_seq,
  input logic [CNT_W-1:0] ld_count,
  input logic             head_valid
);
  // Blocked sequence number as seen at the ports
  logic [SEQ_W-1:0] seen_blk;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_blk <= '0;
    else if (blk_set) seen_blk <= blk_seq;
  end

  a_r1_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready && !commit_valid) |=> ld_count == $past(ld_count) + 1'b1);

  a_r1_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    ld_count <= CNT_W'(DEPTH));

  a_r4_no_spurious_vio: assert property (@(posedge clk) disable iff (!rst_n)
    (!vio_valid && !st_valid) |=> !vio_valid);

  a_r5_vio_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (vio_valid && !vio_ready) |=> (vio_valid && $stable(vio_idx) && $stable(vio_seq)));

  a_r5_vio_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (vio_valid && vio_ready) |=> !vio_valid);

  a_r6_commit_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && !squash_valid && !(alloc_valid && alloc_ready)) |=> ld_count <= $past(ld_count));

  a_r7_squash_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> ld_count <= $past(ld_count));

  a_r8_squash_gates_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |-> !alloc_ready);

  a_r9_blk_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_valid && blk_pending && !blk_set && squash_seq < seen_blk) |=> !blk_pending);

  a_r9_blk_set: assert property (@(posedge clk) disable iff (!rst_n)
    blk_set |=> blk_pending);

  a_r10_empty_head: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_count == '0) |-> !head_valid);
endmodule

bind lq_load_queue lq_load_queue_chk #(
  .DEPTH(DEPTH), .SEQ_W(SEQ_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/sim_lq_load_queue.sv
`timescale 1ns/1ps
module sim_lq_load_queue;
  localparam int DEPTH = 8, SLOTS = DEPTH + 1, SEQ_W = 16, ADDR_W = 32, SQW = 4, SH = 8;
  localparam int IDX_W = $clog2(SLOTS), CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic alloc_valid = 0, alloc_sq_empty = 0, addr_valid = 0, st_valid = 0;
  logic commit_valid = 0, squash_valid = 0, blk_set = 0, vio_ready = 0;
  logic [SEQ_W-1:0] alloc_seq = 0, commit_seq = 0, squash_seq = 0, blk_seq = 0;
  logic [SQW-1:0] alloc_sq_tail = 0;
  logic [IDX_W-1:0] addr_idx = 0, st_ld_idx = 0;
  logic [ADDR_W-1:0] addr_value = 0, st_addr = 0;
  logic alloc_ready, blk_pending, vio_valid, head_valid;
  logic [IDX_W-1:0] alloc_idx, vio_idx, ld_tail;
  logic [SEQ_W-1:0] vio_seq, head_seq;
  logic [CNT_W-1:0] ld_count;
  logic signed [SQW:0] head_sq_idx;

  lq_load_queue #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .SQ_IDX_W(SQW), .BLK_SHIFT(SH)) u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Reference state
  int m_seq [SLOTS], m_sqi [SLOTS];
  longint m_addr [SLOTS];
  bit m_ok [SLOTS];
  int m_head = 0, m_tail = 0, m_cnt = 0;
  bit m_vio = 0; int m_vio_idx = 0, m_vio_seq = 0;
  bit m_blk = 0; int m_blk_seq = 0;
  int next_seq = 1;

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int blk_of(longint a);
    return int'(a >> SH);
  endfunction

  function automatic bit exp_ready();
    return !squash_valid && m_cnt < DEPTH;
  endfunction

  function automatic void model_step();
    bit rdy;
    rdy = exp_ready();
    if (m_vio) begin
      if (vio_ready) m_vio = 0;
    end else if (st_valid) begin
      int s, gap;
      s = int'(st_ld_idx);
      gap = (m_tail - s + SLOTS) % SLOTS;
      for (int k = 0; k < gap; k++) begin
        int i;
        i = (s + k) % SLOTS;
        if (m_ok[i] && blk_of(m_addr[i]) == blk_of(longint'(st_addr))) begin
          m_vio = 1; m_vio_idx = i; m_vio_seq = m_seq[i];
          break;
        end
      end
    end
    if (squash_valid) begin
      while (m_cnt > 0 && m_seq[(m_tail + SLOTS - 1) % SLOTS] > int'(squash_seq)) begin
        m_tail = (m_tail + SLOTS - 1) % SLOTS; m_cnt--;
      end
    end else if (commit_valid) begin
      while (m_cnt > 0 && m_seq[m_head] <= int'(commit_seq)) begin
        m_head = (m_head + 1) % SLOTS; m_cnt--;
      end
    end
    if (blk_set) begin m_blk = 1; m_blk_seq = int'(blk_seq); end
    else if (squash_valid && m_blk && int'(squash_seq) < m_blk_seq) m_blk = 0;
    if (addr_valid) begin m_addr[addr_idx] = longint'(addr_value); m_ok[addr_idx] = 1; end
    if (alloc_valid && rdy) begin
      m_seq[m_tail] = int'(alloc_seq);
      m_ok[m_tail] = 0;
      m_sqi[m_tail] = alloc_sq_empty ? -1 : int'(alloc_sq_tail);
      m_tail = (m_tail + 1) % SLOTS; m_cnt++;
    end
  endfunction

  task automatic compare_all();
    chk("R1 count", ld_count, m_cnt);
    chk("R1/R7 tail", ld_tail, m_tail);
    chk("R6 head_valid", head_valid, m_cnt > 0);
    if (m_cnt > 0) begin
      chk("R6 head_seq", head_seq, m_seq[m_head]);
      chk("R2 head_sq_idx", head_sq_idx, m_sqi[m_head]);
    end
    chk("R5 vio_valid", vio_valid, m_vio);
    if (m_vio) begin
      chk("R4 vio_idx", vio_idx, m_vio_idx);
      chk("R4 vio_seq", vio_seq, m_vio_seq);
    end
    chk("R9 blk_pending", blk_pending, m_blk);
  endtask

  // Inputs are set at a negedge; outputs are compared at the following negedge.
  task automatic tick();
    #1;
    chk("R1/R8 alloc_ready", alloc_ready, exp_ready());
    if (alloc_valid) chk("R1 alloc_idx", alloc_idx, m_tail);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    alloc_valid = 0; addr_valid = 0; st_valid = 0; commit_valid = 0;
    squash_valid = 0; blk_set = 0; vio_ready = 0; alloc_sq_empty = 0;
  endtask

  task automatic do_alloc(int s, bit sq_empty, int sq_tail);
    idle(); alloc_valid = 1; alloc_seq = SEQ_W'(s);
    alloc_sq_empty = sq_empty; alloc_sq_tail = SQW'(sq_tail);
    tick();
  endtask

  task automatic do_addr(int slot, longint a);
    idle(); addr_valid = 1; addr_idx = IDX_W'(slot); addr_value = ADDR_W'(a); tick();
  endtask

  task automatic do_store(int start, longint a);
    idle(); st_valid = 1; st_ld_idx = IDX_W'(start); st_addr = ADDR_W'(a); tick();
  endtask

  task automatic do_squash(int s);
    idle(); squash_valid = 1; squash_seq = SEQ_W'(s); tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    chk("R10 count", ld_count, 0);
    chk("R10 tail", ld_tail, 0);
    chk("R10 vio", vio_valid, 0);
    chk("R10 blk", blk_pending, 0);
    chk("R10 head_valid", head_valid, 0);

    // R1/R2: fill to capacity
    for (int k = 0; k < DEPTH; k++) begin
      do_alloc(10 + k, k == 0, k);
      if (k == 0) chk("R2 empty sq gives -1", head_sq_idx, -1);
    end
    idle(); alloc_valid = 1; alloc_seq = 99; #1;
    chk("R1 full blocks alloc", alloc_ready, 0);
    tick();
    chk("R1 count stays at DEPTH", ld_count, DEPTH);

    // R3/R4: first executed match after start wins; slot 1 is unexecuted
    do_addr(2, 'h280);
    do_addr(3, 'h200);
    do_addr(4, 'h2FF);
    do_store(1, 'h2FF);
    chk("R4 first offender slot", vio_idx, 2);
    chk("R4 first offender seq", vio_seq, 12);
    // R5: check while held is ignored
    do_store(3, 'h200);
    chk("R5 held payload", vio_idx, 2);
    idle(); vio_ready = 1; tick();
    chk("R5 cleared after read", vio_valid, 0);
    // R3: unexecuted loads never match
    do_store(5, 'h2FF);
    chk("R3 unexecuted no match", vio_valid, 0);
    // R4: block boundary at BLK_SHIFT
    do_store(3, 'h1FF);
    chk("R4 other block no match", vio_valid, 0);

    // R6: commit stops at first younger entry
    idle(); commit_valid = 1; commit_seq = 13; tick();
    chk("R6 commit run", ld_count, 4);
    chk("R6 new head", head_seq, 14);
    // R8: squash wins, commit ignored
    idle(); commit_valid = 1; commit_seq = 17; squash_valid = 1; squash_seq = 15; tick();
    chk("R8 commit ignored under squash", head_seq, 14);
    chk("R7 squash count", ld_count, 2);

    // R7: wrap across slot 0 on squash
    for (int k = 0; k < 6; k++) do_alloc(20 + k, 0, 3);
    chk("R1 tail wrapped", ld_tail, 3);
    // R9: blocked load handling
    idle(); blk_set = 1; blk_seq = 21; tick();
    do_squash(21);
    chk("R7 tail back across 0", ld_tail, 8);
    chk("R7 count after wrap squash", ld_count, 4);
    chk("R9 equal seq keeps blocked", blk_pending, 1);
    do_squash(20);
    chk("R9 older squash clears", blk_pending, 0);
    next_seq = 30;

    // Random traffic
    for (int cyc = 0; cyc < 4000; cyc++) begin
      idle();
      if ($urandom_range(0, 99) < 50) begin
        alloc_valid = 1; alloc_seq = SEQ_W'(next_seq);
        alloc_sq_empty = $urandom_range(0, 3) == 0; alloc_sq_tail = SQW'($urandom_range(0, 15));
      end
      if (m_cnt > 0 && $urandom_range(0, 99) < 40) begin
        addr_valid = 1;
        addr_idx = IDX_W'((m_head + $urandom_range(0, m_cnt - 1)) % SLOTS);
        addr_value = ADDR_W'(($urandom_range(0, 3) << 8) | $urandom_range(0, 255));
      end
      if ($urandom_range(0, 99) < 25) begin
        st_valid = 1;
        st_ld_idx = IDX_W'((m_head + $urandom_range(0, m_cnt)) % SLOTS);
        st_addr = ADDR_W'(($urandom_range(0, 3) << 8) | $urandom_range(0, 255));
      end
      if (m_cnt > 0 && $urandom_range(0, 99) < 15) begin
        commit_valid = 1; commit_seq = SEQ_W'(m_seq[m_head] - 1 + $urandom_range(0, 4));
      end
      if (m_cnt > 0 && $urandom_range(0, 99) < 7) begin
        int nw;
        nw = m_seq[(m_tail + SLOTS - 1) % SLOTS] - $urandom_range(0, 4);
        squash_valid = 1; squash_seq = SEQ_W'(nw < 0 ? 0 : nw);
      end
      if ($urandom_range(0, 99) < 5) begin
        blk_set = 1; blk_seq = SEQ_W'(next_seq - $urandom_range(0, 6));
      end
      vio_ready = $urandom_range(0, 99) < 30;
      if (alloc_valid && exp_ready()) next_seq++;
      tick();
    end
    finish_run();
  end
endmodule